// File: doc/BRIEF.md
# Flag Threshold Register Sequencer

This block owns the two threshold values that a FIFO's flag logic compares against its fill level: an empty-side offset, used for the almost-empty flag, and a full-side offset, used for the almost-full flag. One mode input, `cfg_access`, takes over the normal data ports. While it is high, write-enabled write-clock edges stop storing FIFO data. Instead they load the low twelve bits of the write word into the threshold registers. Read-enabled read-clock edges stop reading FIFO data and return a threshold register on the low bits of the read port.

Each side keeps its own register pointer. The write pointer and the read pointer each step through the sequence empty-offset, full-offset, empty-offset, and so on. Neither pointer moves on a cycle that does not access a register. Leaving configuration mode part-way through the sequence keeps the pointer where it is, so the next access picks up at the following register.

When `cfg_access` is low, the block passes the enable to the FIFO storage as a plain request strobe. Both thresholds are available in the write clock domain. A copy of both is also kept in the read clock domain. That copy is refreshed only while configuration mode is off, because the source registers do not change then.

Top module: `offset_load_seq`

## Requirements
- R1: After reset, both threshold registers and both read-domain copies hold the default offset: 31 when FIFO_DEPTH is 256 or less, 63 when it is 512 or less, and 127 otherwise. Both register pointers select the empty-side offset, and `rd_data` is zero.
- R2: With `cfg_access` high and `wr_en` high, each write-clock edge stores `wr_data[11:0]` into the selected register. The first such edge after reset selects the empty-side offset, the second selects the full-side offset, and the third selects the empty-side offset again.
- R3: With `cfg_access` high and `wr_en` low, a write-clock edge stores nothing and does not move the write pointer.
- R4: With `cfg_access` low, `fifo_wr_req` equals `wr_en`, `fifo_wr_data` equals `wr_data`, and no threshold register changes. With `cfg_access` high, `fifo_wr_req` is low.
- R5: When `cfg_access` is dropped and raised again, the next register write goes to the register after the last one written.
- R6: With `cfg_access` high and `rd_en` high, a read-clock edge loads the selected register into `rd_data`, zero-extended. A dedicated read pointer selects the register. It starts at the empty-side offset, alternates on each such edge, and is independent of the write pointer.
- R7: Only bits 11:0 of a write word are stored. Bits of `rd_data` above bit 11 always read zero.
- R8: `rd_data` keeps its value on every read-clock edge that is not a register read.
- R9: `ofs_empty_r` and `ofs_full_r` take the threshold values within five read-clock edges after `cfg_access` falls. They do not change once `cfg_access` has been high for two read-clock edges.
- R10: `fifo_rd_req` equals `rd_en` while `cfg_access` is low, and is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_access | input | 1 | High: the enables access the threshold registers instead of the FIFO |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Write word; bits 11:0 carry a threshold value in configuration mode |
| rd_en | input | 1 | Read enable |
| fifo_wr_req | output | 1 | Write strobe to the FIFO storage |
| fifo_wr_data | output | DATA_W | Write word forwarded to the FIFO storage |
| fifo_rd_req | output | 1 | Read strobe to the FIFO storage |
| rd_data | output | DATA_W | Register readback word; upper bits are zero |
| ofs_empty_w | output | OFS_W | Empty-side threshold, write domain |
| ofs_full_w | output | OFS_W | Full-side threshold, write domain |
| ofs_empty_r | output | OFS_W | Empty-side threshold, read-domain copy |
| ofs_full_r | output | OFS_W | Full-side threshold, read-domain copy |

## Verification
The bench builds the block with its defaults: an 18-bit data word, 12-bit thresholds and a depth of 256, so reset yields 31 in both registers. The bench drives both clocks from one source. Because of this, the pointer rotation, the wrap to the empty-side register, the resume after a mode exit, and the refresh delay of the read-domain copy all fall on known edges. A write word with its upper bits set shows that only the low twelve bits are stored.

// File: rtl/ofsld_pkg.sv
package ofsld_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  function automatic int unsigned default_offset(input int unsigned depth);
    if (depth <= 256) return 31;
    else if (depth <= 512) return 63;
    return 127;
  endfunction

  function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

endpackage

// File: rtl/ofsld_wr_port.sv
module ofsld_wr_port
  import ofsld_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int OFS_W   = 12,
  parameter int DEF_OFS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_access,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fifo_wr_req,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic [OFS_W-1:0]  ofs_empty,
  output logic [OFS_W-1:0]  ofs_full
);
  localparam int NREG = 2;
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEF_OFS);

  ofs_sel_e                   wsel_q;
  logic [NREG-1:0][OFS_W-1:0] ofs_vec;
  logic                       prog_wr;

  assign prog_wr      = cfg_access & wr_en;
  assign fifo_wr_req  = wr_en & ~cfg_access;
  assign fifo_wr_data = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wsel_q <= SEL_EMPTY;
    else if (prog_wr) wsel_q <= next_sel(wsel_q);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam ofs_sel_e MY_SEL = (g == 0) ? SEL_EMPTY : SEL_FULL;
    logic [OFS_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else if (prog_wr && wsel_q == MY_SEL) q <= wr_data[OFS_W-1:0];
    end
    assign ofs_vec[g] = q;
  end

  assign ofs_empty = ofs_vec[0];
  assign ofs_full  = ofs_vec[1];

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_wr |=> $stable(wsel_q));
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_wr |=> wsel_q != $past(wsel_q));
  p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_wr |=> $stable(ofs_vec));
  p_one_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_wr |=> $countones({ofs_empty != $past(ofs_empty),
                            ofs_full != $past(ofs_full)}) <= 1);

endmodule

// File: rtl/ofsld_rd_port.sv
module ofsld_rd_port
  import ofsld_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_access,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  ofs_empty,
  input  logic [OFS_W-1:0]  ofs_full,
  output logic              fifo_rd_req,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - OFS_W;

  ofs_sel_e         rsel_q;
  logic [OFS_W-1:0] rd_q;
  logic             prog_rd;
  logic [OFS_W-1:0] sel_val;

  assign prog_rd     = cfg_access & rd_en;
  assign fifo_rd_req = rd_en & ~cfg_access;
  assign sel_val     = (rsel_q == SEL_EMPTY) ? ofs_empty : ofs_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= SEL_EMPTY;
      rd_q   <= '0;
    end else if (prog_rd) begin
      rsel_q <= next_sel(rsel_q);
      rd_q   <= sel_val;
    end
  end

  if (PAD_W > 0) begin : g_pad
    assign rd_data = {{PAD_W{1'b0}}, rd_q};
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:OFS_W] == '0);
  end else begin : g_nopad
    assign rd_data = rd_q[DATA_W-1:0];
  end

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_rd |=> $stable(rd_data));
  p_rd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_rd |=> rsel_q != $past(rsel_q));

endmodule

// File: rtl/ofsld_shadow.sv
module ofsld_shadow #(
  parameter int OFS_W   = 12,
  parameter int DEF_OFS = 31,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_access,
  input  logic [OFS_W-1:0] src_empty,
  input  logic [OFS_W-1:0] src_full,
  output logic [OFS_W-1:0] dst_empty,
  output logic [OFS_W-1:0] dst_full
);
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEF_OFS);

  logic [SYNC_N-1:0] sync_q;
  logic              busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], cfg_access};
  end

  assign busy = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_empty <= RST_VAL;
      dst_full  <= RST_VAL;
    end else if (!busy) begin
      dst_empty <= src_empty;
      dst_full  <= src_full;
    end
  end

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({dst_empty, dst_full}));

endmodule

// File: rtl/offset_load_seq.sv
module offset_load_seq
  import ofsld_pkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int OFS_W      = 12,
  parameter int FIFO_DEPTH = 256
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_access,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              fifo_wr_req,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              fifo_rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [OFS_W-1:0]  ofs_empty_w,
  output logic [OFS_W-1:0]  ofs_full_w,
  output logic [OFS_W-1:0]  ofs_empty_r,
  output logic [OFS_W-1:0]  ofs_full_r
);
  localparam int DEF_OFS = int'(default_offset(FIFO_DEPTH));

  ofsld_wr_port #(.DATA_W(DATA_W), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .cfg_access(cfg_access), .wr_en(wr_en),
    .wr_data(wr_data), .fifo_wr_req(fifo_wr_req), .fifo_wr_data(fifo_wr_data),
    .ofs_empty(ofs_empty_w), .ofs_full(ofs_full_w)
  );

  ofsld_rd_port #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .cfg_access(cfg_access), .rd_en(rd_en),
    .ofs_empty(ofs_empty_w), .ofs_full(ofs_full_w),
    .fifo_rd_req(fifo_rd_req), .rd_data(rd_data)
  );

  ofsld_shadow #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS), .SYNC_N(2)) u_shadow (
    .clk(rd_clk), .rst_n(rst_n), .cfg_access(cfg_access),
    .src_empty(ofs_empty_w), .src_full(ofs_full_w),
    .dst_empty(ofs_empty_r), .dst_full(ofs_full_r)
  );

endmodule

// File: tb/test_offset_load_seq.sv
module test_offset_load_seq;
  localparam int DW = 18;
  localparam int OW = 12;

  typedef struct packed {
    logic          cfg;
    logic          wen;
    logic          ren;
    logic [DW-1:0] wdat;
    logic [OW-1:0] exp_e;
    logic [OW-1:0] exp_f;
    logic [DW-1:0] exp_rd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b0, 18'h30045, 12'h045, 12'h01F, 18'h0},     // R2 R7 first -> empty
    '{1'b1, 1'b0, 1'b0, 18'h00111, 12'h045, 12'h01F, 18'h0},     // R3
    '{1'b1, 1'b1, 1'b0, 18'h000A0, 12'h045, 12'h0A0, 18'h0},     // R2 second -> full
    '{1'b1, 1'b1, 1'b0, 18'h00222, 12'h222, 12'h0A0, 18'h0},     // R2 wrap
    '{1'b0, 1'b1, 1'b0, 18'h00333, 12'h222, 12'h0A0, 18'h0},     // R4
    '{1'b1, 1'b1, 1'b0, 18'h00444, 12'h222, 12'h444, 18'h0},     // R5 resume
    '{1'b1, 1'b0, 1'b1, 18'h0,     12'h222, 12'h444, 18'h00222}, // R6
    '{1'b1, 1'b0, 1'b1, 18'h0,     12'h222, 12'h444, 18'h00444}, // R6
    '{1'b0, 1'b0, 1'b1, 18'h0,     12'h222, 12'h444, 18'h00444}, // R8 R10
    '{1'b1, 1'b0, 1'b0, 18'h0,     12'h222, 12'h444, 18'h00444}, // R8
    '{1'b1, 1'b0, 1'b1, 18'h0,     12'h222, 12'h444, 18'h00222}, // R6 wrap
    '{1'b1, 1'b1, 1'b0, 18'h00FFF, 12'hFFF, 12'h444, 18'h00222}  // R6 independent of write ptr
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_access = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic fifo_wr_req, fifo_rd_req;
  logic [DW-1:0] fifo_wr_data, rd_data;
  logic [OW-1:0] ofs_empty_w, ofs_full_w, ofs_empty_r, ofs_full_r;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  offset_load_seq i_offset_load_seq (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .cfg_access(cfg_access),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .fifo_wr_req(fifo_wr_req), .fifo_wr_data(fifo_wr_data),
    .fifo_rd_req(fifo_rd_req), .rd_data(rd_data),
    .ofs_empty_w(ofs_empty_w), .ofs_full_w(ofs_full_w),
    .ofs_empty_r(ofs_empty_r), .ofs_full_r(ofs_full_r)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic w, input logic r, input logic [DW-1:0] d);
    cfg_access = c; wr_en = w; rd_en = r; wr_data = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, '0);
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 empty_w", 32'(ofs_empty_w), 32'h1F);
    chk("R1 full_w", 32'(ofs_full_w), 32'h1F);
    chk("R1 empty_r", 32'(ofs_empty_r), 32'h1F);
    chk("R1 full_r", 32'(ofs_full_r), 32'h1F);
    chk("R1 rd_data", 32'(rd_data), 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cfg, VEC[i].wen, VEC[i].ren, VEC[i].wdat);
      #1;
      chk("R4 fifo_wr_req", 32'(fifo_wr_req), 32'(VEC[i].wen & ~VEC[i].cfg));
      chk("R10 fifo_rd_req", 32'(fifo_rd_req), 32'(VEC[i].ren & ~VEC[i].cfg));
      if (!VEC[i].cfg) chk("R4 fifo_wr_data", 32'(fifo_wr_data), 32'(VEC[i].wdat));
      step();
      chk("R2 empty_w", 32'(ofs_empty_w), 32'(VEC[i].exp_e));
      chk("R2 full_w", 32'(ofs_full_w), 32'(VEC[i].exp_f));
      chk("R6 rd_data", 32'(rd_data), 32'(VEC[i].exp_rd));
    end

    // R9: copy follows after mode exit
    drive(1'b0, 1'b0, 1'b0, '0);
    for (int k = 0; k < 5; k++) step();
    chk("R9 empty_r refresh", 32'(ofs_empty_r), 32'hFFF);
    chk("R9 full_r refresh", 32'(ofs_full_r), 32'h444);

    // R9: copy frozen during configuration
    drive(1'b1, 1'b0, 1'b0, '0);
    for (int k = 0; k < 3; k++) step();
    drive(1'b1, 1'b1, 1'b0, 18'h00555);
    step();
    drive(1'b1, 1'b0, 1'b0, '0);
    chk("R2 full_w after resume", 32'(ofs_full_w), 32'h555);
    step(); step();
    chk("R9 full_r frozen", 32'(ofs_full_r), 32'h444);
    drive(1'b0, 1'b0, 1'b0, '0);
    for (int k = 0; k < 5; k++) step();
    chk("R9 full_r updated", 32'(ofs_full_r), 32'h555);

    // R1: pointers return to empty register after reset
    do_reset();
    chk("R1 full_w after reset", 32'(ofs_full_w), 32'h1F);
    drive(1'b1, 1'b1, 1'b0, 18'h000AB);
    step();
    chk("R1 wr ptr at empty", 32'(ofs_empty_w), 32'hAB);
    chk("R1 full untouched", 32'(ofs_full_w), 32'h1F);
    drive(1'b1, 1'b0, 1'b1, '0);
    step();
    chk("R1 rd ptr at empty", 32'(rd_data), 32'hAB);
    drive(1'b0, 1'b0, 1'b0, '0);
    step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule